// File: doc/BRIEF.md
# SDRAM Byte-Lane Mask Data Path

This block sits between a synchronous DRAM memory array and its 16-bit data bus. The bus is split into two 8-bit byte lanes, and each lane has its own mask line. In the write direction the mask acts in the same cycle as the data: a lane whose mask is low produces a write strobe toward the array, and a lane whose mask is high produces no strobe, so the stored byte keeps its old value. In the read direction the mask acts as a per-lane output enable with a fixed latency of two clocks. A mask sampled low in a read cycle makes that lane drive array data two clocks later. A mask sampled high turns that lane's driver off two clocks later.

A two-bit mode input selects the direction for each cycle. The codes are idle, write and read, and the spare code behaves as idle. When no read is in flight, every lane driver is off. The bus is modelled as separate input, output and per-lane enable ports, so the enclosing pad ring or model can build the tri-state from them. Array addressing and command decoding are handled elsewhere.

Top module: `sdram_lane_mask_path`

## Requirements
- R1: In a cycle with mode code 2'b01 (write), `arr_wstrb_o[l]` is 1 exactly when `mask_i[l]` is 0, in the same cycle with no register delay. Lane 0 covers bits 7:0 and lane 1 covers bits 15:8.
- R2: A lane whose mask is high during a write leaves the stored byte in the array unchanged, while the unmasked lane of the same word is updated.
- R3: `arr_wdata_o` equals `dq_i` in the same cycle.
- R4: When the mode is read (code 2'b10) and `mask_i[l]` is 0 at a clock edge, `dq_oe_o[l]` is 1 and `dq_o` lane l equals `arr_rdata_i` lane l in the cycle that follows the second edge after it, that is, two clocks later.
- R5: When the mode is read and `mask_i[l]` is 1 at a clock edge, `dq_oe_o[l]` is 0 two clocks later.
- R6: Each mask bit affects only its own lane, in both directions.
- R7: With mode 2'b00 (idle) or the spare code 2'b11, no write strobe is raised in that cycle, and both lane enables are 0 two clocks later.
- R8: While `rst_n` is low, `arr_wstrb_o` and `dq_oe_o` are all 0, whatever the mode and mask inputs are.
- R9: A lane whose enable is 0 outputs zeros on `dq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_i | input | 2 | Cycle direction: 00 idle, 01 write, 10 read, 11 idle |
| mask_i | input | 2 | Per-lane mask; bit 0 is bits 7:0, bit 1 is bits 15:8 |
| dq_i | input | 16 | Write data from the bus |
| dq_o | output | 16 | Read data toward the bus, zero on disabled lanes |
| dq_oe_o | output | 2 | Per-lane bus driver enable |
| arr_wdata_o | output | 16 | Write data toward the array |
| arr_wstrb_o | output | 2 | Per-lane write strobe toward the array |
| arr_rdata_i | input | 16 | Read data from the array |

## Verification
The write path holds no state, so a wrong strobe shows at once in the same cycle and leaves a corrupted byte in the array model, which the final memory compare exposes. The read path keeps a small amount of state: one delayed enable bit per lane. A stuck or mis-shifted stage shows up at the ports as a lane enable arriving one clock early or late, or landing on the wrong lane. The per-cycle two-clock comparison against the bench's own history catches this within two cycles of the stimulus that triggers it. Directed cases cover single-lane masks in both directions, the spare mode code, and inputs applied while the block is held in reset.

// File: rtl/sdram_dp_pkg.sv
package sdram_dp_pkg;
  typedef enum logic [1:0] {
    DP_IDLE  = 2'b00,
    DP_WRITE = 2'b01,
    DP_READ  = 2'b10,
    DP_SPARE = 2'b11
  } dp_mode_e;
endpackage

// File: rtl/sdram_dp_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module sdram_dp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sdram_dp_wr_lane.sv
// Write lane: the mask gates the strobe in the same cycle as the data.
module sdram_dp_wr_lane #(
  parameter int LANE_W = 8
) (
  input  logic              wr_act_i,
  input  logic              mask_i,
  input  logic [LANE_W-1:0] data_i,
  output logic              strb_o,
  output logic [LANE_W-1:0] data_o
);
  always_comb begin
    strb_o = wr_act_i & ~mask_i;
    data_o = data_i;
  end
endmodule

// File: rtl/sdram_dp_rd_lane.sv
// Read lane: the enable is delayed RD_LAT clocks before it drives the lane.
module sdram_dp_rd_lane #(
  parameter int LANE_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_act_i,
  input  logic              mask_i,
  input  logic [LANE_W-1:0] rdata_i,
  output logic [LANE_W-1:0] dq_o,
  output logic              oe_o
);
  logic [RD_LAT-1:0] pipe_q;
  logic [RD_LAT-1:0] pipe_d;
  logic              en_in;
  logic              pipe_ce;

  assign en_in   = rd_act_i & ~mask_i;
  assign pipe_ce = 1'b1;  // the lane shifts every clock

  generate
    if (RD_LAT > 1) begin : g_deep
      always_comb begin
        pipe_d = {pipe_q[RD_LAT-2:0], en_in};
      end
    end else begin : g_single
      always_comb begin
        pipe_d = en_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pipe_q <= '0;
    else if (pipe_ce) pipe_q <= pipe_d;
  end

  assign oe_o = pipe_q[RD_LAT-1];
  assign dq_o = oe_o ? rdata_i : '0;
endmodule

// File: rtl/sdram_lane_mask_path.sv
module sdram_lane_mask_path #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_i,
  input  logic [LANES-1:0]         mask_i,
  input  logic [LANES*LANE_W-1:0]  dq_i,
  output logic [LANES*LANE_W-1:0]  dq_o,
  output logic [LANES-1:0]         dq_oe_o,
  output logic [LANES*LANE_W-1:0]  arr_wdata_o,
  output logic [LANES-1:0]         arr_wstrb_o,
  input  logic [LANES*LANE_W-1:0]  arr_rdata_i
);
  import sdram_dp_pkg::*;

  localparam int DW = LANES * LANE_W;

  logic     rst_sync_n;
  logic     wr_act;
  logic     rd_act;
  dp_mode_e mode;

  sdram_dp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    mode   = dp_mode_e'(mode_i);
    wr_act = rst_sync_n && (mode == DP_WRITE);
    rd_act = (mode == DP_READ);
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      sdram_dp_wr_lane #(.LANE_W(LANE_W)) u_wr (
        .wr_act_i (wr_act),
        .mask_i   (mask_i[l]),
        .data_i   (dq_i[l*LANE_W +: LANE_W]),
        .strb_o   (arr_wstrb_o[l]),
        .data_o   (arr_wdata_o[l*LANE_W +: LANE_W])
      );

      sdram_dp_rd_lane #(.LANE_W(LANE_W), .RD_LAT(RD_LAT)) u_rd (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .rd_act_i (rd_act),
        .mask_i   (mask_i[l]),
        .rdata_i  (arr_rdata_i[l*LANE_W +: LANE_W]),
        .dq_o     (dq_o[l*LANE_W +: LANE_W]),
        .oe_o     (dq_oe_o[l])
      );
    end
  endgenerate

  logic [DW-1:0] unused_width_probe;
  assign unused_width_probe = '0;
endmodule

// File: rtl/sdram_lane_mask_path_chk.sv
module sdram_lane_mask_path_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int RD_LAT = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              mode_i,
  input logic [LANES-1:0]        mask_i,
  input logic [LANES*LANE_W-1:0] dq_o,
  input logic [LANES-1:0]        dq_oe_o,
  input logic [LANES-1:0]        arr_wstrb_o
);
  import sdram_dp_pkg::*;

  logic [2:0] since_rst;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end
  assign armed = (since_rst >= 3'd4);

  // R8: reset holds strobes and enables low
  a_r8_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (arr_wstrb_o == '0 && dq_oe_o == '0));

  // R7: no write strobe outside write mode
  a_r7_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != DP_WRITE) |-> (arr_wstrb_o == '0));

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_chk
      // R1: a strobe needs write mode and a low mask on that lane
      a_r1_strobe_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wstrb_o[l] |-> (mode_i == DP_WRITE && !mask_i[l]));

      // R9: a disabled lane outputs zeros
      a_r9_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe_o[l] |-> (dq_o[l*LANE_W +: LANE_W] == '0));

      if (RD_LAT == 2) begin : g_lat2
        // R4 and R5: the lane enable follows read mode and mask two clocks late
        a_r4_oe_two_late: assert property (@(posedge clk) disable iff (!rst_n)
          armed |-> (dq_oe_o[l] == ($past(mode_i, 2) == DP_READ && !$past(mask_i[l], 2))));
      end
    end
  endgenerate
endmodule

bind sdram_lane_mask_path sdram_lane_mask_path_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .RD_LAT(RD_LAT)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .mask_i      (mask_i),
  .dq_o        (dq_o),
  .dq_oe_o     (dq_oe_o),
  .arr_wstrb_o (arr_wstrb_o)
);

// File: tb/sdram_lane_mask_path_tb_top.sv
module sdram_lane_mask_path_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 16;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic [1:0]  mask_i;
  logic [15:0] dq_i;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe_o;
  logic [15:0] arr_wdata_o;
  logic [1:0]  arr_wstrb_o;
  logic [15:0] arr_rdata_i;

  logic [15:0] mem     [WORDS];
  logic [15:0] exp_mem [WORDS];
  logic [3:0]  addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // history of the two previous steps: index 0 newest
  logic [1:0] h_mode [2];
  logic [1:0] h_mask [2];
  logic [15:0] obs_dq;
  logic [1:0]  obs_oe;

  sdram_lane_mask_path dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mask_i(mask_i),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .arr_wdata_o(arr_wdata_o), .arr_wstrb_o(arr_wstrb_o),
    .arr_rdata_i(arr_rdata_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // array model: written only through the block's strobes
  always @(posedge clk) begin
    for (int l = 0; l < 2; l++)
      if (arr_wstrb_o[l]) mem[addr][l*8 +: 8] <= arr_wdata_o[l*8 +: 8];
  end
  assign arr_rdata_i = mem[addr];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_oe(input logic [1:0] m, input logic [1:0] k);
    return (m == 2'b10) ? ~k : 2'b00;
  endfunction

  function automatic logic [15:0] exp_dq(input logic [1:0] oe, input logic [15:0] rd);
    return {oe[1] ? rd[15:8] : 8'h00, oe[0] ? rd[7:0] : 8'h00};
  endfunction

  // one bench cycle: check read path vs two steps ago, drive, check write path
  task automatic step(input logic [1:0] m, input logic [1:0] k,
                      input logic [15:0] d, input logic [3:0] a);
    logic [1:0] eo;
    @(negedge clk);
    obs_dq = dq_o;
    obs_oe = dq_oe_o;
    eo = exp_oe(h_mode[1], h_mask[1]);
    if (h_mode[1] == 2'b10) begin
      check((h_mask[1] == 2'b00) ? "R4 lane enable" : "R5/R6 lane enable", {30'd0, obs_oe}, {30'd0, eo});
    end else begin
      check("R7 enable released", {30'd0, obs_oe}, {30'd0, eo});
    end
    check("R4/R9 read data", {16'd0, obs_dq}, {16'd0, exp_dq(eo, arr_rdata_i)});
    h_mode[1] = h_mode[0]; h_mask[1] = h_mask[0];
    h_mode[0] = m;         h_mask[0] = k;
    mode_i = m; mask_i = k; dq_i = d; addr = a;
    #1;
    if (m == 2'b01) begin
      check("R1/R6 write strobe", {30'd0, arr_wstrb_o}, {30'd0, ~k});
      for (int l = 0; l < 2; l++)
        if (!k[l]) exp_mem[a][l*8 +: 8] = d[l*8 +: 8];
    end else begin
      check("R7 no strobe", {30'd0, arr_wstrb_o}, 32'd0);
    end
    check("R3 write data", {16'd0, arr_wdata_o}, {16'd0, d});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) begin mem[i] = 16'h0000; exp_mem[i] = 16'h0000; end
    for (int i = 0; i < 2; i++) begin h_mode[i] = 2'b00; h_mask[i] = 2'b00; end
    rst_n = 1'b0; mode_i = 2'b01; mask_i = 2'b00; dq_i = 16'hFFFF; addr = 4'd0;

    // R8: inputs asking for a write and a read while reset is held
    repeat (3) @(negedge clk);
    #1;
    check("R8 strobe in reset", {30'd0, arr_wstrb_o}, 32'd0);
    check("R8 enable in reset", {30'd0, dq_oe_o}, 32'd0);
    mode_i = 2'b10;
    @(negedge clk); #1;
    check("R8 enable in reset with read", {30'd0, dq_oe_o}, 32'd0);
    mode_i = 2'b00; dq_i = 16'h0000;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed: full write, upper-masked write, fully masked write (R1, R2, R6)
    step(2'b01, 2'b00, 16'hA5C3, 4'd3);
    step(2'b01, 2'b10, 16'h1234, 4'd3);
    step(2'b00, 2'b00, 16'h0000, 4'd3);
    check("R2 upper lane kept", {16'd0, mem[3]}, {16'd0, 16'hA534});
    step(2'b01, 2'b11, 16'hFFFF, 4'd3);
    step(2'b00, 2'b00, 16'h0000, 4'd3);
    check("R2 both lanes kept", {16'd0, mem[3]}, {16'd0, 16'hA534});

    // directed: read with lower lane masked (R5, R6)
    step(2'b10, 2'b01, 16'h0000, 4'd3);
    step(2'b00, 2'b00, 16'h0000, 4'd3);
    step(2'b00, 2'b00, 16'h0000, 4'd3);
    check("R5 lower lane off, upper drives", {16'd0, obs_dq}, {16'd0, 16'hA500});
    check("R6 enable pattern", {30'd0, obs_oe}, 32'd2);

    // directed: spare code with mask low acts as idle (R7)
    step(2'b11, 2'b00, 16'hBEEF, 4'd3);
    step(2'b00, 2'b00, 16'h0000, 4'd3);
    step(2'b00, 2'b00, 16'h0000, 4'd3);
    check("R7 spare code no enable", {30'd0, obs_oe}, 32'd0);
    check("R2 spare code no write", {16'd0, mem[3]}, {16'd0, 16'hA534});

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0] m;
      m = 2'($urandom % 4);
      step(m, 2'($urandom % 4), 16'($urandom), 4'($urandom % WORDS));
    end
    step(2'b00, 2'b00, 16'h0000, 4'd0);
    step(2'b00, 2'b00, 16'h0000, 4'd0);
    for (int i = 0; i < WORDS; i++)
      check("R2 memory image", {16'd0, mem[i]}, {16'd0, exp_mem[i]});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule